// File: doc/BRIEF.md
# Storage Key Reference and Change Bit Updater

This block holds one small key per 4 KiB page of absolute storage. It sits after address translation. Each translated access arrives as one request with the absolute address, the access kind (load, store or instruction fetch), a flag saying whether keys are in use, and the permission flags the translator granted. The block looks up the page's key, sets the reference bit, and also sets the change bit when the access is a store. It writes the key back only if its value moved.

It also narrows the returned permissions. A read or fetch of a page whose change bit is still clear comes back without write permission. The first later store to that page must therefore return to translation, and that store records the change bit. When keys are not in use, or the page lies beyond the key array, the flags come back untouched and no key is altered. A separate test port writes any key directly and reads any key back. Its write wins over an update to the same page in the same cycle.

The read-modify-write is pipelined over two cycles. A new request may be presented every cycle. A request that reads a page still being updated by its predecessor, or written by the test port at that edge, sees the newest value.

Top module: `skey_rc_updater`

## Requirements
- R1: After reset every key is 0, and `done_o`, `flags_o` and `key_written_o` are 0.
- R2: The key used is the one at index `req_addr >> PAGE_SHIFT` (4 KiB pages by default). The offset bits within the page play no part.
- R3: Every active load (`req_kind` 2'b00), store (2'b01) or fetch (2'b10) sets the reference bit, key bit 1. Code 2'b11 is treated as a read.
- R4: An active store also sets the change bit, key bit 0, and returns the flags exactly as received.
- R5: On an active read or fetch whose old key has bit 0 clear, write permission (`flags` bit 1) is cleared in `flags_o`. Read (bit 0) and execute (bit 2) pass unchanged. `flags_o` never gains a bit.
- R6: The key is written back, and `key_written_o` pulses with `done_o`, only when the new key differs from the old one.
- R7: With `keys_en` low, `flags_o` equals `flags_in`, `key_written_o` stays 0 and no key changes.
- R8: A page index of `NUM_PAGES` or more is a failed lookup: flags pass through, no key is written, and no aliased key changes.
- R9: `done_o` pulses for exactly one cycle, two clock edges after the edge that accepts a request. Requests may arrive back to back.
- R10: A request to a page updated by the request one cycle ahead uses the updated key.
- R11: A test-port write lands at the next edge and can be read back on `tk_rdata`. It wins over an update to the same page at that edge, and a request accepted at that edge reads the test value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_addr | input | ADDR_W | Validated absolute address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 read |
| keys_en | input | 1 | Storage keys in use |
| flags_in | input | 3 | Granted permissions: bit0 read, bit1 write, bit2 execute |
| done_o | output | 1 | One-cycle completion pulse |
| flags_o | output | 3 | Permissions after key adjustment, valid with done_o |
| key_written_o | output | 1 | The completed request changed its key |
| tk_we | input | 1 | Test-port key write enable |
| tk_page | input | $clog2(NUM_PAGES) | Test-port page index for write and readback |
| tk_wdata | input | 7 | Test-port key value |
| tk_rdata | output | 7 | Current key of page tk_page |

## Verification
An update's writeback and a test-port write can hit the same page at the same edge. The bench provokes this by placing a test write to the page of a store exactly one cycle after the store is accepted. It then judges the result from the readback, which must show the test value. A test write into the page of a request accepted at the same edge is also provoked; the request's flags and write pulse must follow the test value. Random traffic over a handful of pages then makes both overlaps frequent against a cycle model of the key array.

// File: rtl/skey_pkg.sv
package skey_pkg;

    localparam int KEY_W  = 7;
    localparam int FLAG_W = 3;

    // fixed key bit positions
    localparam int REF_BIT = 1;
    localparam int CHG_BIT = 0;

    // permission flag positions
    localparam int FLG_RD = 0;
    localparam int FLG_WR = 1;
    localparam int FLG_EX = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_OTHER = 2'b11
    } acc_kind_e;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [FLAG_W-1:0] flags_t;

endpackage

// File: rtl/skey_page_decode.sv
module skey_page_decode #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_PAGES  = 64
) (
    input  logic [ADDR_W-1:0]            addr,
    output logic [$clog2(NUM_PAGES)-1:0] page,
    output logic                         miss
);
    localparam int PG_W = $clog2(NUM_PAGES);
    localparam int UP_W = ADDR_W - PAGE_SHIFT;
    localparam logic [UP_W-1:0] LIMIT = UP_W'(NUM_PAGES);

    logic [UP_W-1:0] upper;

    always_comb begin
        upper = addr[ADDR_W-1:PAGE_SHIFT];
        page  = upper[PG_W-1:0];
        miss  = (upper >= LIMIT);
    end
endmodule

// File: rtl/skey_modify.sv
module skey_modify
    import skey_pkg::*;
(
    input  key_t       old_key,
    input  logic [1:0] kind,
    input  logic       act,
    input  flags_t     flags_in,
    output key_t       new_key,
    output flags_t     flags_out,
    output logic       changed
);
    logic is_store;

    always_comb begin
        is_store  = (acc_kind_e'(kind) == ACC_STORE);
        new_key   = old_key;
        flags_out = flags_in;
        if (act) begin
            new_key[REF_BIT] = 1'b1;
            if (is_store) begin
                new_key[CHG_BIT] = 1'b1;
            end else if (!old_key[CHG_BIT]) begin
                flags_out[FLG_WR] = 1'b0;
            end
        end
        changed = act && (new_key != old_key);
    end
endmodule

// File: rtl/skey_store.sv
module skey_store
    import skey_pkg::*;
#(
    parameter int NUM_PAGES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wb_en,
    input  logic [$clog2(NUM_PAGES)-1:0] wb_page,
    input  key_t                         wb_key,
    input  logic                         tk_en,
    input  logic [$clog2(NUM_PAGES)-1:0] tk_page,
    input  key_t                         tk_key,
    input  logic [$clog2(NUM_PAGES)-1:0] rd_page,
    output key_t                         rd_key,
    input  logic [$clog2(NUM_PAGES)-1:0] pk_page,
    output key_t                         pk_key
);
    localparam int PG_W = $clog2(NUM_PAGES);

    logic [NUM_PAGES*KEY_W-1:0] flat;

    for (genvar gi = 0; gi < NUM_PAGES; gi++) begin : g_ent
        key_t ent_d, ent_q;
        logic hit_tk, hit_wb;

        always_comb begin
            hit_tk = tk_en && (tk_page == PG_W'(gi));
            hit_wb = wb_en && (wb_page == PG_W'(gi));
            ent_d  = ent_q;
            if (hit_tk) begin
                ent_d = tk_key;
            end else if (hit_wb) begin
                ent_d = wb_key;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign flat[gi*KEY_W +: KEY_W] = ent_q;
    end

    // read port with forwarding of writes landing at the coming edge
    always_comb begin
        rd_key = flat[rd_page*KEY_W +: KEY_W];
        if (tk_en && tk_page == rd_page) begin
            rd_key = tk_key;
        end else if (wb_en && wb_page == rd_page) begin
            rd_key = wb_key;
        end
        pk_key = flat[pk_page*KEY_W +: KEY_W];
    end
endmodule

// File: rtl/skey_rc_updater.sv
module skey_rc_updater
    import skey_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_PAGES  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [1:0]                   req_kind,
    input  logic                         keys_en,
    input  logic [2:0]                   flags_in,
    output logic                         done_o,
    output logic [2:0]                   flags_o,
    output logic                         key_written_o,
    input  logic                         tk_we,
    input  logic [$clog2(NUM_PAGES)-1:0] tk_page,
    input  logic [6:0]                   tk_wdata,
    output logic [6:0]                   tk_rdata
);
    localparam int PG_W = $clog2(NUM_PAGES);

    typedef struct packed {
        logic            vld;
        logic            act;
        logic [1:0]      kind;
        flags_t          flags;
        logic [PG_W-1:0] page;
        key_t            key;
    } cap_t;

    typedef struct packed {
        cap_t   cap;
        logic   done;
        flags_t flags;
        logic   wrote;
    } st_t;

    st_t st_d, st_q;

    logic [PG_W-1:0] dec_page;
    logic            dec_miss;
    key_t            rd_key;
    key_t            mod_key;
    flags_t          mod_flags;
    logic            mod_changed;
    logic            wb_en;

    skey_page_decode #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .NUM_PAGES (NUM_PAGES)
    ) u_dec (
        .addr(req_addr),
        .page(dec_page),
        .miss(dec_miss)
    );

    skey_modify u_mod (
        .old_key  (st_q.cap.key),
        .kind     (st_q.cap.kind),
        .act      (st_q.cap.act),
        .flags_in (st_q.cap.flags),
        .new_key  (mod_key),
        .flags_out(mod_flags),
        .changed  (mod_changed)
    );

    skey_store #(
        .NUM_PAGES(NUM_PAGES)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wb_en  (wb_en),
        .wb_page(st_q.cap.page),
        .wb_key (mod_key),
        .tk_en  (tk_we),
        .tk_page(tk_page),
        .tk_key (tk_wdata),
        .rd_page(dec_page),
        .rd_key (rd_key),
        .pk_page(tk_page),
        .pk_key (tk_rdata)
    );

    always_comb begin
        wb_en = st_q.cap.vld && mod_changed;

        st_d           = st_q;
        st_d.cap.vld   = req_valid;
        st_d.cap.act   = req_valid && keys_en && !dec_miss;
        st_d.cap.kind  = req_kind;
        st_d.cap.flags = flags_in;
        st_d.cap.page  = dec_page;
        st_d.cap.key   = rd_key;

        st_d.done  = st_q.cap.vld;
        st_d.flags = st_q.cap.vld ? mod_flags : '0;
        st_d.wrote = wb_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o        = st_q.done;
    assign flags_o       = st_q.flags;
    assign key_written_o = st_q.wrote;
endmodule

// File: rtl/skey_rc_chk.sv
module skey_rc_chk #(
    parameter int PG_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic            keys_en,
    input logic [2:0]      flags_in,
    input logic            done_o,
    input logic [2:0]      flags_o,
    input logic            key_written_o,
    input logic            tk_we,
    input logic [PG_W-1:0] tk_page,
    input logic [6:0]      tk_wdata,
    input logic [6:0]      tk_rdata
);
    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 done_o);

    // R9
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ##1 !done_o);

    // R6
    written_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_written_o |-> done_o);

    // R5
    flags_never_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((flags_o & ~$past(flags_in, 2)) == 3'b000));

    // R7
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !keys_en) |=> ##1 (flags_o == $past(flags_in, 2) && !key_written_o));

    // R4
    store_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b01) |=> ##1 (flags_o == $past(flags_in, 2)));

    // R11
    test_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tk_we |=> ((tk_page != $past(tk_page)) || (tk_rdata == $past(tk_wdata))));
endmodule

bind skey_rc_updater skey_rc_chk #(
    .PG_W($clog2(NUM_PAGES))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .keys_en      (keys_en),
    .flags_in     (flags_in),
    .done_o       (done_o),
    .flags_o      (flags_o),
    .key_written_o(key_written_o),
    .tk_we        (tk_we),
    .tk_page      (tk_page),
    .tk_wdata     (tk_wdata),
    .tk_rdata     (tk_rdata)
);

// File: tb/skey_rc_updater_bench.sv
`timescale 1ns/1ps
module skey_rc_updater_bench;
    localparam int ADDR_W = 32;
    localparam int NPG    = 64;
    localparam int PG_W   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_kind = 2'b00;
    logic keys_en = 1'b0;
    logic [2:0] flags_in = 3'b000;
    logic done_o, key_written_o;
    logic [2:0] flags_o;
    logic tk_we = 1'b0;
    logic [PG_W-1:0] tk_page = '0;
    logic [6:0] tk_wdata = '0;
    logic [6:0] tk_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    skey_rc_updater u_skey_rc_updater (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .keys_en(keys_en), .flags_in(flags_in),
        .done_o(done_o), .flags_o(flags_o), .key_written_o(key_written_o),
        .tk_we(tk_we), .tk_page(tk_page), .tk_wdata(tk_wdata), .tk_rdata(tk_rdata)
    );

    // reference model state
    logic [6:0] m_mem [NPG];
    logic p_vld, p_act;
    logic [1:0] p_kind;
    logic [2:0] p_flags;
    logic [PG_W-1:0] p_page;
    logic [6:0] p_key;
    logic e_done, e_wb;
    logic [2:0] e_flags;

    function automatic logic [6:0] f_new(logic [6:0] k, logic [1:0] kind, logic act);
        logic [6:0] r = k;
        if (act) begin
            r[1] = 1'b1;                    // R3
            if (kind == 2'b01) r[0] = 1'b1; // R4
        end
        return r;
    endfunction

    function automatic logic [2:0] f_flags(logic [6:0] k, logic [1:0] kind, logic act,
                                           logic [2:0] f);
        logic [2:0] r = f;
        if (act && kind != 2'b01 && !k[0]) r[1] = 1'b0; // R5
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NPG; i++) m_mem[i] = '0;
        p_vld = 0; p_act = 0; p_kind = 0; p_flags = 0; p_page = 0; p_key = 0;
    endtask

    // one clock: model update at the edge, output compare at the falling edge
    task automatic tick();
        logic [6:0] nk;
        logic [31:0] up;
        @(posedge clk);
        nk      = f_new(p_key, p_kind, p_act);
        e_done  = p_vld;
        e_wb    = p_vld && p_act && (nk != p_key);
        e_flags = p_vld ? f_flags(p_key, p_kind, p_act, p_flags) : 3'b000;
        if (e_wb)  m_mem[p_page] = nk;
        if (tk_we) m_mem[tk_page] = tk_wdata;             // R11 priority
        up      = req_addr >> 12;                          // R2
        p_vld   = req_valid;
        p_act   = req_valid && keys_en && (up < NPG);      // R8
        p_kind  = req_kind;
        p_flags = flags_in;
        p_page  = up[PG_W-1:0];
        p_key   = m_mem[p_page];
        @(negedge clk);
        chk("R9 done", {31'd0, done_o}, {31'd0, e_done});
        chk("R5 flags", {29'd0, flags_o}, {29'd0, e_flags});
        chk("R6 written", {31'd0, key_written_o}, {31'd0, e_wb});
        chk("R11 readback", {25'd0, tk_rdata}, {25'd0, m_mem[tk_page]});
    endtask

    task automatic drive(logic [31:0] a, logic [1:0] k, logic en, logic [2:0] f);
        req_valid = 1'b1; req_addr = a; req_kind = k; keys_en = en; flags_in = f;
    endtask

    task automatic quiet();
        req_valid = 1'b0; tk_we = 1'b0;
    endtask

    // issue one request and wait until its result is on the outputs
    task automatic one(logic [31:0] a, logic [1:0] k, logic en, logic [2:0] f);
        drive(a, k, en, f);
        tick();
        quiet();
        tick();
    endtask

    task automatic peek(logic [PG_W-1:0] pg, logic [6:0] exp, string tag);
        tk_page = pg;
        #0.5;
        chk(tag, {25'd0, tk_rdata}, {25'd0, exp});
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 done", {31'd0, done_o}, 0);
        chk("R1 flags", {29'd0, flags_o}, 0);
        chk("R1 written", {31'd0, key_written_o}, 0);
        peek(6'd0, 7'h00, "R1 key0");
        peek(6'd63, 7'h00, "R1 key63");

        // R3 R2 R5 R6: first load of page 3 with an in-page offset
        one(32'h0000_3123, 2'b00, 1'b1, 3'b111);
        chk("R5 load C clear", {29'd0, flags_o}, 3'b101);
        chk("R6 load wrote", {31'd0, key_written_o}, 1);
        peek(6'd3, 7'h02, "R3 R2 ref set");

        // R6: same load again leaves key unchanged
        one(32'h0000_3FFF, 2'b00, 1'b1, 3'b111);
        chk("R6 no rewrite", {31'd0, key_written_o}, 0);

        // R4: store sets change, flags unchanged
        one(32'h0000_3000, 2'b01, 1'b1, 3'b111);
        chk("R4 store flags", {29'd0, flags_o}, 3'b111);
        peek(6'd3, 7'h03, "R4 change set");

        // R5: fetch after change set keeps write
        one(32'h0000_3010, 2'b10, 1'b1, 3'b111);
        chk("R5 fetch C set", {29'd0, flags_o}, 3'b111);

        // R7: keys disabled
        one(32'h0000_4000, 2'b01, 1'b0, 3'b110);
        chk("R7 pass flags", {29'd0, flags_o}, 3'b110);
        chk("R7 no write", {31'd0, key_written_o}, 0);
        peek(6'd4, 7'h00, "R7 key untouched");

        // R8: page 64 is out of range, must not alias page 0
        one(32'h0004_0000, 2'b00, 1'b1, 3'b111);
        chk("R8 pass flags", {29'd0, flags_o}, 3'b111);
        chk("R8 no write", {31'd0, key_written_o}, 0);
        peek(6'd0, 7'h00, "R8 no alias");

        // R10: back-to-back load then store to page 5
        drive(32'h0000_5000, 2'b00, 1'b1, 3'b111);
        tick();
        drive(32'h0000_5008, 2'b01, 1'b1, 3'b111);
        tick();
        quiet();
        chk("R10 first flags", {29'd0, flags_o}, 3'b101);
        tick();
        chk("R10 second flags", {29'd0, flags_o}, 3'b111);
        chk("R10 second wrote", {31'd0, key_written_o}, 1);
        peek(6'd5, 7'h03, "R10 final key");

        // R11: test write collides with writeback to page 6
        drive(32'h0000_6000, 2'b01, 1'b1, 3'b111);
        tick();
        quiet();
        tk_we = 1'b1; tk_page = 6'd6; tk_wdata = 7'h50;
        tick();
        chk("R11 update still reported", {31'd0, key_written_o}, 1);
        quiet();
        peek(6'd6, 7'h50, "R11 test write wins");

        // R11: request accepted at the edge of a test write reads the new key
        tk_we = 1'b1; tk_page = 6'd7; tk_wdata = 7'h02;
        drive(32'h0000_7000, 2'b00, 1'b1, 3'b111);
        tick();
        quiet();
        tick();
        chk("R11 bypass flags", {29'd0, flags_o}, 3'b101);
        chk("R11 bypass no write", {31'd0, key_written_o}, 0);

        // random traffic concentrated on few pages
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'd1234);
        end
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] pg;
            pg = ($urandom % 16 == 0) ? (32'd64 + ($urandom % 4)) : ($urandom % 6);
            req_valid = ($urandom % 4) != 0;
            req_addr  = (pg << 12) | ($urandom % 4096);
            req_kind  = 2'($urandom % 4);
            keys_en   = ($urandom % 8) != 0;
            flags_in  = 3'($urandom % 8);
            tk_we     = ($urandom % 10) == 0;
            tk_page   = 6'($urandom % 6);
            tk_wdata  = 7'($urandom % 128);
            tick();
        end
        quiet();
        tick();
        tick();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule